// File: doc/BRIEF.md
# Slot-Based Bank-Private DRAM Command Scheduler

This block turns memory requests from a multithreaded core into DRAM commands so that every access takes a fixed, known time. Each hardware thread owns one bank, and the bank number equals the thread number. Time is split into slots of `SLOT_LEN` cycles. The slots are handed to threads 0, 1, … `NT-1` in a fixed rotation, which matches the core's own issue order. A thread's request is served only in that thread's own slot, using a closed-page sequence: open the row, do the column read or write, then close the bank. There is no queue and no reordering, so the latency of a request never depends on what other threads, or earlier requests, did.

Refresh works one bank at a time, as a row open followed by a close (RAS-only), with no global all-bank refresh. A bank is refreshed only in its owner's slot, and only when that owner has no request waiting, so refresh can never delay an access. Each bank keeps its own refresh row pointer and counts the rows it has refreshed in the current refresh period. A bank that misses its quota in a period raises a sticky error flag.

Command encoding on `cmd_o`: 0 = no operation, 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = refresh activate (RAS-only).

Top module: `slot_dram_sched`

## Requirements
- R1: While `rst_n` is low, `cmd_o` is 0 (no operation), `done_o` is all zero and `ref_err_o` is all zero.
- R2: Slots start at the first clock edge after reset is released. Slot k belongs to thread k mod `NT` and lasts `SLOT_LEN` cycles. Every command other than no-operation carries `cmd_bank_o` equal to the thread that owns the current slot.
- R3: A served access drives three commands in a fixed order:
  - In the slot's first cycle, activate (1) with the request row.
  - In the next cycle, read (2) if the request was latched with `we_i` = 0, or write (3) if it was latched with `we_i` = 1, with the same row.
  - In the cycle after that, precharge (4).
  - In the remaining cycles of the slot, no operation.
- R4: `done_o[t]` is high for exactly one cycle, three cycles after the first cycle of the slot that served thread t. This timing does not depend on the traffic of any other thread.
- R5: A request on `req_i[t]` sampled at a clock edge before the edge that starts thread t's slot is served in that slot. A request sampled at that edge or later waits for thread t's next slot. It is never served in another thread's slot.
- R6: Each thread has at most one outstanding request. A request on `req_i[t]` sampled from the edge that latched the previous request up to and including the edge that raises its `done_o[t]` is ignored, together with its row and write flag.
- R7: In a slot whose owner has no pending request and whose bank still needs refresh in the current period, the block issues refresh activate (5) in the slot's first cycle with that bank's refresh row. It issues precharge (4) two cycles later.
- R8: Each bank's refresh row starts at 0 after reset. It advances by one after each refresh of that bank and wraps at 2^`ROW_W`.
- R9: Refresh periods are `REF_PERIOD` cycles long and start at the first edge after reset. Each bank is refreshed at most `REF_ROWS` times per period. An idle slot whose bank has met its quota carries no operation.
- R10: A pending request always takes its thread's slot ahead of refresh. The refresh row of that bank is not advanced in that slot.
- R11: `ref_err_o[b]` rises at the end of any period in which bank b completed fewer than `REF_ROWS` refreshes. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NT | Per-thread request pulse |
| we_i | input | NT | Per-thread write flag, latched with the request |
| row_i | input | NT*ROW_W | Per-thread row address, thread t at bits [t*ROW_W +: ROW_W] |
| cmd_o | output | 3 | DRAM command code |
| cmd_bank_o | output | $clog2(NT) | Bank targeted by the command |
| cmd_row_o | output | ROW_W | Row for activate, column, and refresh commands; 0 otherwise |
| done_o | output | NT | Per-thread completion pulse |
| ref_err_o | output | NT | Per-bank sticky refresh-deadline error |

## Verification
The bench places requests on both sides of a slot boundary:
- A request sampled one edge before its slot start must be served in that slot.
- A request sampled exactly at the slot start must wait a full rotation. A design that compares against the wrong edge would either serve it early or drop a slot.

A request sent while another is still pending must leave no trace. A design that does not guard its latch would serve the wrong row, or would serve a phantom second access in the following rotation.

Refresh is checked in three ways:
- Row numbering and the per-period quota, including the restart of the count after a period boundary.
- The yield to a pending request, where a wrong design would either steal the slot or advance the refresh row without refreshing.
- A thread kept busy for a whole period, which must flag only its own bank.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_RACT = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_ACCESS  = 2'd1,
        SLOT_REFRESH = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/sds_slot_timer.sv
// Fixed slot rotation and refresh period counter.
module sds_slot_timer #(
    parameter int NT         = 4,
    parameter int SLOT_LEN   = 4,
    parameter int REF_PERIOD = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [$clog2(NT)-1:0]         thr_o,
    output logic [$clog2(SLOT_LEN)-1:0]   nxt_phase_o,
    output logic [$clog2(NT)-1:0]         nxt_thr_o,
    output logic                          wrap_o
);
    localparam int TW   = $clog2(NT);
    localparam int PW   = $clog2(SLOT_LEN);
    localparam int PERW = $clog2(REF_PERIOD);

    typedef struct packed {
        logic [PW-1:0]   phase;
        logic [TW-1:0]   thr;
        logic [PERW-1:0] per;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.phase == PW'(SLOT_LEN - 1)) begin
            t_d.phase = '0;
            t_d.thr   = (t_q.thr == TW'(NT - 1)) ? '0 : t_q.thr + TW'(1);
        end else begin
            t_d.phase = t_q.phase + PW'(1);
        end
        t_d.per = (t_q.per == PERW'(REF_PERIOD - 1)) ? '0 : t_q.per + PERW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.phase <= PW'(SLOT_LEN - 1);
            t_q.thr   <= TW'(NT - 1);
            t_q.per   <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign thr_o       = t_q.thr;
    assign nxt_phase_o = t_d.phase;
    assign nxt_thr_o   = t_d.thr;
    assign wrap_o      = (t_q.per == PERW'(REF_PERIOD - 1));
endmodule

// File: rtl/sds_thread_port.sv
// One outstanding request per thread, latched until its completion.
module sds_thread_port #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             clear_i,
    output logic             pending_o,
    output logic             we_o,
    output logic [ROW_W-1:0] row_o
);
    typedef struct packed {
        logic             pend;
        logic             we;
        logic [ROW_W-1:0] row;
    } port_t;

    port_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (clear_i) begin
            p_d.pend = 1'b0;
        end else if (!p_q.pend && req_i) begin
            p_d.pend = 1'b1;
            p_d.we   = we_i;
            p_d.row  = row_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pending_o = p_q.pend;
    assign we_o      = p_q.we;
    assign row_o     = p_q.row;
endmodule

// File: rtl/sds_refresh_bank.sv
// Per-bank refresh row pointer, period quota and deadline flag.
module sds_refresh_bank #(
    parameter int ROW_W    = 8,
    parameter int REF_ROWS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             wrap_i,
    output logic             need_o,
    output logic [ROW_W-1:0] row_o,
    output logic             err_o
);
    localparam int CW = $clog2(REF_ROWS + 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    cnt;
        logic             err;
    } rb_t;

    rb_t r_d, r_q;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        r_d    = r_q;
        cnt_nx = r_q.cnt;
        if (fire_i) begin
            cnt_nx  = r_q.cnt + CW'(1);
            r_d.row = r_q.row + ROW_W'(1);
        end
        if (wrap_i) begin
            if (cnt_nx < CW'(REF_ROWS)) r_d.err = 1'b1;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign need_o = (r_q.cnt < CW'(REF_ROWS));
    assign row_o  = r_q.row;
    assign err_o  = r_q.err;
endmodule

// File: rtl/slot_dram_sched.sv
// Top: fixed-slot, bank-private DRAM command scheduler.
module slot_dram_sched #(
    parameter int NT         = 4,
    parameter int ROW_W      = 8,
    parameter int SLOT_LEN   = 4,   // at least 4: act, column, precharge, done
    parameter int REF_PERIOD = 256,
    parameter int REF_ROWS   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          req_i,
    input  logic [NT-1:0]          we_i,
    input  logic [NT*ROW_W-1:0]    row_i,
    output logic [2:0]             cmd_o,
    output logic [$clog2(NT)-1:0]  cmd_bank_o,
    output logic [ROW_W-1:0]       cmd_row_o,
    output logic [NT-1:0]          done_o,
    output logic [NT-1:0]          ref_err_o
);
    import sds_pkg::*;

    localparam int TW      = $clog2(NT);
    localparam int PW      = $clog2(SLOT_LEN);
    localparam int DONE_PH = 3;

    typedef struct packed {
        slot_kind_e       kind;
        logic [2:0]       cmd;
        logic [TW-1:0]    bank;
        logic [ROW_W-1:0] row;
        logic [NT-1:0]    done;
    } seq_t;

    seq_t s_d, s_q;

    logic [TW-1:0]    slot_thr;
    logic [TW-1:0]    nxt_thr;
    logic [PW-1:0]    nxt_phase;
    logic             per_wrap;
    logic [NT-1:0]    pend, pwe, need, fire, clear, rerr;
    logic [ROW_W-1:0] prow [NT];
    logic [ROW_W-1:0] rrow [NT];

    sds_slot_timer #(
        .NT(NT), .SLOT_LEN(SLOT_LEN), .REF_PERIOD(REF_PERIOD)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .thr_o(slot_thr),
        .nxt_phase_o(nxt_phase), .nxt_thr_o(nxt_thr), .wrap_o(per_wrap)
    );

    for (genvar t = 0; t < NT; t++) begin : g_thr
        sds_thread_port #(.ROW_W(ROW_W)) u_port (
            .clk(clk), .rst_n(rst_n),
            .req_i(req_i[t]), .we_i(we_i[t]), .row_i(row_i[t*ROW_W +: ROW_W]),
            .clear_i(clear[t]),
            .pending_o(pend[t]), .we_o(pwe[t]), .row_o(prow[t])
        );
        sds_refresh_bank #(.ROW_W(ROW_W), .REF_ROWS(REF_ROWS)) u_ref (
            .clk(clk), .rst_n(rst_n),
            .fire_i(fire[t]), .wrap_i(per_wrap),
            .need_o(need[t]), .row_o(rrow[t]), .err_o(rerr[t])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.bank = '0;
        s_d.row  = '0;
        s_d.done = '0;
        fire     = '0;
        clear    = '0;
        // slot-start decision: a waiting request beats refresh
        if (nxt_phase == '0) begin
            if (pend[nxt_thr]) begin
                s_d.kind = SLOT_ACCESS;
            end else if (need[nxt_thr]) begin
                s_d.kind      = SLOT_REFRESH;
                fire[nxt_thr] = 1'b1;
            end else begin
                s_d.kind = SLOT_IDLE;
            end
        end
        if (s_d.kind == SLOT_ACCESS) begin
            if (nxt_phase == '0) begin
                s_d.cmd  = CMD_ACT;
                s_d.bank = nxt_thr;
                s_d.row  = prow[nxt_thr];
            end else if (nxt_phase == PW'(1)) begin
                s_d.cmd  = pwe[nxt_thr] ? CMD_WR : CMD_RD;
                s_d.bank = nxt_thr;
                s_d.row  = prow[nxt_thr];
            end else if (nxt_phase == PW'(2)) begin
                s_d.cmd  = CMD_PRE;
                s_d.bank = nxt_thr;
            end else if (nxt_phase == PW'(DONE_PH)) begin
                s_d.done[slot_thr] = 1'b1;
                clear[slot_thr]    = 1'b1;
            end
        end else if (s_d.kind == SLOT_REFRESH) begin
            if (nxt_phase == '0) begin
                s_d.cmd  = CMD_RACT;
                s_d.bank = nxt_thr;
                s_d.row  = rrow[nxt_thr];
            end else if (nxt_phase == PW'(2)) begin
                s_d.cmd  = CMD_PRE;
                s_d.bank = nxt_thr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= SLOT_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o      = s_q.cmd;
    assign cmd_bank_o = s_q.bank;
    assign cmd_row_o  = s_q.row;
    assign done_o     = s_q.done;
    assign ref_err_o  = rerr;
endmodule

// File: rtl/sds_sched_chk.sv
module sds_sched_chk #(
    parameter int NT = 4,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cmd_o,
    input logic [TW-1:0] cmd_bank_o,
    input logic [NT-1:0] done_o,
    input logic [NT-1:0] ref_err_o,
    input logic [TW-1:0] slot_thr
);
    AST_BANK_IS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 3'd0) |-> (cmd_bank_o == slot_thr)); // R2
    AST_ACT_THEN_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd1) |=> (cmd_o == 3'd2 || cmd_o == 3'd3)); // R3
    AST_COLUMN_THEN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd2 || cmd_o == 3'd3) |=> (cmd_o == 3'd4)); // R3
    AST_DONE_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> ($past(cmd_o) == 3'd4)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o)); // R4
    AST_DONE_TO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> (done_o == (NT'(1) << slot_thr))); // R4
    AST_REFRESH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd5) |-> ##2 (cmd_o == 3'd4)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ref_err_o & $past(ref_err_o)) == $past(ref_err_o))); // R11
endmodule

bind slot_dram_sched sds_sched_chk #(.NT(NT), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .done_o(done_o), .ref_err_o(ref_err_o), .slot_thr(slot_thr)
);

// File: tb/tb_slot_dram_sched.sv
`timescale 1ns/1ps
module tb_slot_dram_sched;
    localparam int NT = 4, RW = 8, SL = 4, RND = NT * SL;
    localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_RACT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] req = '0, we = '0;
    logic [NT*RW-1:0] row = '0;
    logic [2:0]    cmd_o;
    logic [1:0]    cmd_bank_o;
    logic [RW-1:0] cmd_row_o;
    logic [NT-1:0] done_o, ref_err_o;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;

    slot_dram_sched dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .row_i(row),
        .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_row_o(cmd_row_o),
        .done_o(done_o), .ref_err_o(ref_err_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ne(string tag, int act, int bad);
        n_chk++;
        if (act == bad) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=not %0d", tag, act, bad);
        end
    endtask

    // index of the last clock edge, valid at a negedge
    function automatic int now();
        return cyc - 1;
    endfunction

    task automatic at_n(int m);
        while (now() < m) @(negedge clk);
    endtask

    task automatic align(int p);
        while (((now() % RND) + RND) % RND != p) @(negedge clk);
    endtask

    function automatic int next_slot(int t, int m);
        int s = m;
        while (s % RND != t * SL) s++;
        return s;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req = '0; we = '0; row = '0;
        repeat (4) @(negedge clk);
        chk("R1 cmd in reset", int'(cmd_o), C_NOP);
        chk("R1 done in reset", int'(done_o), 0);
        chk("R1 err in reset", int'(ref_err_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic set_req(int t, int r, bit w);
        req[t] = 1'b1; we[t] = w; row[t*RW +: RW] = RW'(r);
        @(negedge clk);
        req[t] = 1'b0;
    endtask

    task automatic expect_access(int t, int s, int r, bit w, string tag);
        at_n(s);
        chk({tag, " R3 act"}, int'(cmd_o), C_ACT);
        chk({tag, " R2 act bank"}, int'(cmd_bank_o), t);
        chk({tag, " R3 act row"}, int'(cmd_row_o), r);
        at_n(s + 1);
        chk({tag, " R3 column"}, int'(cmd_o), w ? C_WR : C_RD);
        chk({tag, " R3 column row"}, int'(cmd_row_o), r);
        at_n(s + 2);
        chk({tag, " R3 pre"}, int'(cmd_o), C_PRE);
        chk({tag, " R4 no early done"}, int'(done_o), 0);
        at_n(s + 3);
        chk({tag, " R4 done"}, int'(done_o), 1 << t);
        chk({tag, " R3 idle tail"}, int'(cmd_o), C_NOP);
    endtask

    task automatic t_refresh();
        do_reset();
        for (int r = 0; r < 5; r++) begin
            for (int t = 0; t < NT; t++) begin
                at_n(r * RND + t * SL);
                if (r < 4) begin
                    chk("R7 refresh act", int'(cmd_o), C_RACT);
                    chk("R2 refresh bank", int'(cmd_bank_o), t);
                    chk("R8 refresh row", int'(cmd_row_o), r);
                    at_n(r * RND + t * SL + 2);
                    chk("R7 refresh pre", int'(cmd_o), C_PRE);
                end else begin
                    chk("R9 quota met", int'(cmd_o), C_NOP);
                end
            end
        end
        for (int t = 0; t < NT; t++) begin
            at_n(256 + t * SL);
            chk("R9 new period refresh", int'(cmd_o), C_RACT);
            chk("R8 row continues", int'(cmd_row_o), 4);
        end
    endtask

    task automatic t_read();
        int m = now();
        set_req(1, 8'h5A, 1'b0);
        expect_access(1, next_slot(1, m + 2), 8'h5A, 1'b0, "read");
    endtask

    task automatic t_write();
        int m = now();
        set_req(2, 8'hC3, 1'b1);
        expect_access(2, next_slot(2, m + 2), 8'hC3, 1'b1, "write");
    endtask

    task automatic t_all();
        int s;
        align(RND - 2);
        s = now() + 2;
        req = '1; we = 4'b1010; row = {8'h44, 8'h33, 8'h22, 8'h11};
        @(negedge clk);
        req = '0;
        for (int t = 0; t < NT; t++)
            expect_access(t, s + t * SL, 8'h11 * (t + 1), we[t], "all R4");
    endtask

    task automatic t_boundary();
        int s;
        align(3 * SL - 2);
        s = now() + 2;
        set_req(3, 8'hE1, 1'b0);
        expect_access(3, s, 8'hE1, 1'b0, "R5 last edge");
        align(3 * SL - 1);
        s = now() + 1;
        set_req(3, 8'hE2, 1'b1);
        at_n(s);
        chk_ne("R5 late not served", int'(cmd_o), C_ACT);
        at_n(s + 3);
        chk("R5 late no done", int'(done_o), 0);
        expect_access(3, s + RND, 8'hE2, 1'b1, "R5 next slot");
    endtask

    task automatic t_ignore();
        int m = now();
        int s;
        set_req(2, 8'h11, 1'b0);
        set_req(2, 8'h22, 1'b1);
        s = next_slot(2, m + 2);
        expect_access(2, s, 8'h11, 1'b0, "R6 first kept");
        at_n(s + RND);
        chk_ne("R6 second ignored", int'(cmd_o), C_ACT);
        at_n(s + RND + 3);
        chk("R6 no second done", int'(done_o), 0);
    endtask

    task automatic t_priority();
        do_reset();
        set_req(2, 8'h77, 1'b1);
        expect_access(2, 8, 8'h77, 1'b1, "R10 access wins");
        at_n(24);
        chk("R10 refresh deferred", int'(cmd_o), C_RACT);
        chk("R10 refresh row kept", int'(cmd_row_o), 0);
    endtask

    task automatic t_deadline();
        do_reset();
        req[0] = 1'b1; row[RW-1:0] = 8'h01; we[0] = 1'b0;
        while (now() < 300) begin
            @(negedge clk);
            req[0] = done_o[0];
            if (now() == 250) chk("R11 no early flag", int'(ref_err_o), 0);
        end
        req[0] = 1'b0;
        chk("R11 starved bank flagged", int'(ref_err_o[0]), 1);
        chk("R11 other banks clean", int'(ref_err_o[3:1]), 0);
    endtask

    initial begin
        t_refresh();
        t_read();
        t_write();
        t_all();
        t_boundary();
        t_ignore();
        t_priority();
        t_deadline();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule